// File: doc/BRIEF.md
# Three-Channel Multi-Mode Timer Bank

The block holds three 32-bit timer channels that share one register bus. Each channel owns a single pin, which is bidirectional at the chip level and appears here as an input, an output value and an output enable. A channel runs in one of three modes. In waveform mode it drives a repeating pulse. In capture mode it measures the high time and the full period of an incoming signal. In watchdog mode it expires when the input stops producing edges for too long.

A control word at address 0 turns each channel on or off on its own. The same word reports a sticky event flag and a sticky watchdog overflow flag for each channel, and these flags are cleared by writing 1 to them. Each channel has four words at base 4*(i+1): configuration (+0), count (+1), period (+2) and pulse width (+3). Reads are combinational. Writes take effect on the rising clock edge. A channel's interrupt output is its event flag gated by its interrupt-enable bit.

Top module: `gpt_bank`

## Requirements
- R1: After reset every register reads 0, every pinOe and pinOut bit is 0, and every irq bit is 0.
- R2: Bits [2:0] of address 0 are read/write enables, one per channel, and each channel is independent of the others. A disabled channel holds its count. A bus write to the count word is accepted only while that channel is disabled.
- R3: The 6-bit configuration word has these fields:
  - bits [1:0]: mode (00 idle, 01 waveform, 10 capture, 11 watchdog).
  - bit 2: pin polarity inversion.
  - bit 3: interrupt enable.
  - bit 4: pin drive enable.

  A configuration write is ignored while the channel is enabled.
- R4: In waveform mode with period P ≥ 1, the count runs 0,1,…,P-1 and repeats. pinOut is (count < width) XOR polarity. pinOe is 1 only while the channel is enabled in waveform mode with bit 4 set.
- R5: In waveform mode each wrap to 0 sets the channel's event flag (address 0, bit 8+i). The flag stays set until it is cleared.
- R6: In capture mode a polarity-adjusted rising edge starts a measurement. The next falling edge stores the high time in clocks into the width word. The rising edge after that stores the full period in clocks into the period word.
- R7: In capture mode each period capture sets the event flag.
- R8: In watchdog mode each polarity-adjusted rising edge reloads the count to 0. While edges keep arriving faster than every P clocks, neither flag is set.
- R9: In watchdog mode, P clocks without an edge set both the event flag and the overflow flag (address 0, bit 16+i). Only watchdog mode can set the overflow flag.
- R10: Writing 1 to a flag bit at address 0 clears it. An event in the same cycle wins over the clear.
- R11: irq[i] is 1 exactly when channel i's event flag and its interrupt-enable bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrite | input | 1 | Write strobe for the register bus |
| busAddr | input | 4 | Word address |
| busWData | input | 32 | Write data |
| busRData | output | 32 | Read data for busAddr |
| pinIn | input | 3 | Sampled level of each channel pin |
| pinOut | output | 3 | Level each channel drives onto its pin |
| pinOe | output | 3 | Drive enable of each channel pin |
| irq | output | 3 | Interrupt request of each channel |

## Verification
Waveform mode is run twice: once with a narrow duty and straight polarity, once with a wider duty and inverted polarity. The pin is compared cycle by cycle, so an off-by-one in the wrap point, the compare or the inversion shows up. Capture mode is given two pulse trains with different high and low lengths, which separates the width capture from the period capture. A re-enable between the trains shows that the measurement restarts cleanly. Watchdog mode first receives steady edges that must never trip it, then goes silent so that it must trip, which separates the edge reload from the expiry.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
  localparam int CFG_W = 6;
  localparam int MODE_LSB = 0;
  localparam int POL_BIT = 2;
  localparam int IRQEN_BIT = 3;
  localparam int DRIVE_BIT = 4;

  typedef enum logic [1:0] {
    MODE_IDLE = 2'b00,
    MODE_WAVE = 2'b01,
    MODE_CAPT = 2'b10,
    MODE_WDOG = 2'b11
  } tmr_mode_e;

  typedef enum logic [1:0] {
    CAP_WAIT = 2'b00,
    CAP_HIGH = 2'b01,
    CAP_LOW  = 2'b10
  } cap_state_e;

  // strobes from the control to the datapath of one channel
  typedef struct packed {
    logic cntStep;
    logic cntZero;
    logic cntOne;
    logic grabWidth;
    logic grabPeriod;
  } tmr_strobe_t;
endpackage

// File: rtl/gpt_datapath.sv
module gpt_datapath #(
  parameter int CNT_W = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 enable,
  input  gpt_pkg::tmr_strobe_t strobe,
  input  logic                 cntWr,
  input  logic                 perWr,
  input  logic                 widWr,
  input  logic [CNT_W-1:0]     wrData,
  output logic [CNT_W-1:0]     count,
  output logic [CNT_W-1:0]     period,
  output logic [CNT_W-1:0]     width,
  output logic                 atTerm,
  output logic                 belowWidth
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (strobe.cntZero) begin
      count <= '0;
    end else if (strobe.cntOne) begin
      count <= ONE;
    end else if (strobe.cntStep) begin
      count <= count + ONE;
    end else if (cntWr && !enable) begin
      count <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      period <= '0;
    end else if (strobe.grabPeriod) begin
      period <= count;
    end else if (perWr) begin
      period <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      width <= '0;
    end else if (strobe.grabWidth) begin
      width <= count;
    end else if (widWr) begin
      width <= wrData;
    end
  end

  assign atTerm     = (count >= (period - ONE));
  assign belowWidth = (count < width);
endmodule

// File: rtl/gpt_ctrl.sv
module gpt_ctrl
  import gpt_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             cfgWr,
  input  logic [CFG_W-1:0] cfgWData,
  input  logic             pinIn,
  input  logic             atTerm,
  input  logic             belowWidth,
  output tmr_strobe_t      strobe,
  output logic [CFG_W-1:0] cfg,
  output logic             pinOut,
  output logic             pinOe,
  output logic             evt,
  output logic             wdExpire
);
  tmr_mode_e  mode;
  logic       pol;
  logic [1:0] syncQ;
  logic       prevLvl;
  logic       lvl;
  logic       rise;
  logic       fall;
  cap_state_e capState;
  cap_state_e capNext;

  assign mode = tmr_mode_e'(cfg[MODE_LSB +: 2]);
  assign pol  = cfg[POL_BIT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg <= '0;
    end else if (cfgWr && !enable) begin
      cfg <= cfgWData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ   <= '0;
      prevLvl <= 1'b0;
    end else begin
      syncQ   <= {syncQ[0], pinIn};
      prevLvl <= lvl;
    end
  end

  assign lvl  = syncQ[1] ^ pol;
  assign rise = lvl & ~prevLvl;
  assign fall = ~lvl & prevLvl;

  always_comb begin
    strobe   = '0;
    evt      = 1'b0;
    wdExpire = 1'b0;
    capNext  = CAP_WAIT;
    if (enable) begin
      unique case (mode)
        MODE_WAVE: begin
          if (atTerm) begin
            strobe.cntZero = 1'b1;
            evt            = 1'b1;
          end else begin
            strobe.cntStep = 1'b1;
          end
        end
        MODE_CAPT: begin
          capNext = capState;
          unique case (capState)
            CAP_WAIT: begin
              if (rise) begin
                strobe.cntOne = 1'b1;
                capNext       = CAP_HIGH;
              end
            end
            CAP_HIGH: begin
              strobe.cntStep = 1'b1;
              if (fall) begin
                strobe.grabWidth = 1'b1;
                capNext          = CAP_LOW;
              end
            end
            CAP_LOW: begin
              if (rise) begin
                strobe.grabPeriod = 1'b1;
                strobe.cntOne     = 1'b1;
                evt               = 1'b1;
                capNext           = CAP_HIGH;
              end else begin
                strobe.cntStep = 1'b1;
              end
            end
            default: capNext = CAP_WAIT;
          endcase
        end
        MODE_WDOG: begin
          if (rise) begin
            strobe.cntZero = 1'b1;
          end else if (atTerm) begin
            strobe.cntZero = 1'b1;
            evt            = 1'b1;
            wdExpire       = 1'b1;
          end else begin
            strobe.cntStep = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capState <= CAP_WAIT;
    end else begin
      capState <= capNext;
    end
  end

  assign pinOe  = enable && (mode == MODE_WAVE) && cfg[DRIVE_BIT];
  assign pinOut = (enable && (mode == MODE_WAVE)) ? (belowWidth ^ pol) : 1'b0;
endmodule

// File: rtl/gpt_bank.sv
module gpt_bank #(
  parameter int NUM_TMR = 3,
  parameter int CNT_W   = 32,
  parameter int ADDR_W  = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busWrite,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [CNT_W-1:0]   busWData,
  output logic [CNT_W-1:0]   busRData,
  input  logic [NUM_TMR-1:0] pinIn,
  output logic [NUM_TMR-1:0] pinOut,
  output logic [NUM_TMR-1:0] pinOe,
  output logic [NUM_TMR-1:0] irq
);
  import gpt_pkg::*;

  localparam int PEND_LSB = 8;
  localparam int OVF_LSB  = 16;
  localparam int SEL_W    = ADDR_W - 2;

  logic [NUM_TMR-1:0]             enReg;
  logic [NUM_TMR-1:0]             pendReg;
  logic [NUM_TMR-1:0]             ovfReg;
  logic [NUM_TMR-1:0]             tmrEvt;
  logic [NUM_TMR-1:0]             tmrExp;
  logic [NUM_TMR-1:0]             irqEn;
  logic [NUM_TMR-1:0][CFG_W-1:0]  cfgArr;
  logic [NUM_TMR-1:0][CNT_W-1:0]  cntArr;
  logic [NUM_TMR-1:0][CNT_W-1:0]  perArr;
  logic [NUM_TMR-1:0][CNT_W-1:0]  widArr;
  logic                           ctlWr;

  assign ctlWr = busWrite && (busAddr == '0);

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    logic        sel;
    tmr_strobe_t strobe;
    logic        atTerm;
    logic        belowWidth;

    assign sel = busWrite && (busAddr[ADDR_W-1:2] == SEL_W'(i + 1));

    gpt_ctrl u_ctrl (
      .clk        (clk),
      .rstN       (rstN),
      .enable     (enReg[i]),
      .cfgWr      (sel && (busAddr[1:0] == 2'd0)),
      .cfgWData   (busWData[CFG_W-1:0]),
      .pinIn      (pinIn[i]),
      .atTerm     (atTerm),
      .belowWidth (belowWidth),
      .strobe     (strobe),
      .cfg        (cfgArr[i]),
      .pinOut     (pinOut[i]),
      .pinOe      (pinOe[i]),
      .evt        (tmrEvt[i]),
      .wdExpire   (tmrExp[i])
    );

    gpt_datapath #(.CNT_W(CNT_W)) u_dp (
      .clk        (clk),
      .rstN       (rstN),
      .enable     (enReg[i]),
      .strobe     (strobe),
      .cntWr      (sel && (busAddr[1:0] == 2'd1)),
      .perWr      (sel && (busAddr[1:0] == 2'd2)),
      .widWr      (sel && (busAddr[1:0] == 2'd3)),
      .wrData     (busWData),
      .count      (cntArr[i]),
      .period     (perArr[i]),
      .width      (widArr[i]),
      .atTerm     (atTerm),
      .belowWidth (belowWidth)
    );

    assign irqEn[i] = cfgArr[i][IRQEN_BIT];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg   <= '0;
      pendReg <= '0;
      ovfReg  <= '0;
    end else begin
      if (ctlWr) begin
        enReg <= busWData[NUM_TMR-1:0];
      end
      for (int i = 0; i < NUM_TMR; i++) begin
        pendReg[i] <= tmrEvt[i] | (pendReg[i] & ~(ctlWr & busWData[PEND_LSB + i]));
        ovfReg[i]  <= tmrExp[i] | (ovfReg[i] & ~(ctlWr & busWData[OVF_LSB + i]));
      end
    end
  end

  assign irq = pendReg & irqEn;

  always_comb begin
    busRData = '0;
    if (busAddr == '0) begin
      for (int i = 0; i < NUM_TMR; i++) begin
        busRData[i]            = enReg[i];
        busRData[PEND_LSB + i] = pendReg[i];
        busRData[OVF_LSB + i]  = ovfReg[i];
      end
    end else begin
      for (int i = 0; i < NUM_TMR; i++) begin
        if (busAddr[ADDR_W-1:2] == SEL_W'(i + 1)) begin
          unique case (busAddr[1:0])
            2'd0: busRData = CNT_W'(cfgArr[i]);
            2'd1: busRData = cntArr[i];
            2'd2: busRData = perArr[i];
            default: busRData = widArr[i];
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/gpt_bank_chk.sv
module gpt_bank_chk #(
  parameter int NUM_TMR = 3,
  parameter int CNT_W   = 32,
  parameter int ADDR_W  = 4,
  parameter int CFG_W   = 6
) (
  input logic                            clk,
  input logic                            rstN,
  input logic                            busWrite,
  input logic [ADDR_W-1:0]               busAddr,
  input logic [CNT_W-1:0]                busWData,
  input logic [NUM_TMR-1:0]              enReg,
  input logic [NUM_TMR-1:0]              pendReg,
  input logic [NUM_TMR-1:0]              ovfReg,
  input logic [NUM_TMR-1:0]              tmrEvt,
  input logic [NUM_TMR-1:0][CFG_W-1:0]   cfgArr,
  input logic [NUM_TMR-1:0][CNT_W-1:0]   cntArr
);
  for (genvar i = 0; i < NUM_TMR; i++) begin : g_chk
    assert_cfg_locked_R3: assert property (@(posedge clk) disable iff (!rstN)
      enReg[i] |=> $stable(cfgArr[i]));

    assert_hold_when_off_R2: assert property (@(posedge clk) disable iff (!rstN)
      (!enReg[i] && !(busWrite && busAddr == ADDR_W'(4 * (i + 1) + 1)))
        |=> $stable(cntArr[i]));

    assert_w1c_clears_R10: assert property (@(posedge clk) disable iff (!rstN)
      (busWrite && busAddr == '0 && busWData[8 + i] && !tmrEvt[i]) |=> !pendReg[i]);

    assert_pend_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
      (pendReg[i] && !(busWrite && busAddr == '0 && busWData[8 + i])) |=> pendReg[i]);

    assert_ovf_only_wdog_R9: assert property (@(posedge clk) disable iff (!rstN)
      $rose(ovfReg[i]) |-> $past(cfgArr[i][1:0] == 2'b11));
  end
endmodule

bind gpt_bank gpt_bank_chk #(
  .NUM_TMR (NUM_TMR),
  .CNT_W   (CNT_W),
  .ADDR_W  (ADDR_W),
  .CFG_W   (gpt_pkg::CFG_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busWrite (busWrite),
  .busAddr  (busAddr),
  .busWData (busWData),
  .enReg    (enReg),
  .pendReg  (pendReg),
  .ovfReg   (ovfReg),
  .tmrEvt   (tmrEvt),
  .cfgArr   (cfgArr),
  .cntArr   (cntArr)
);

// File: tb/gpt_bank_tb.sv
module gpt_bank_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrite = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [31:0] busWData = '0;
  logic [31:0] busRData;
  logic [2:0]  pinIn = '0;
  logic [2:0]  pinOut;
  logic [2:0]  pinOe;
  logic [2:0]  irq;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  logic  expQ[$];
  string expTag[$];

  always #2 clk = ~clk;

  gpt_bank u_dut (
    .clk(clk), .rstN(rstN), .busWrite(busWrite), .busAddr(busAddr),
    .busWData(busWData), .busRData(busRData), .pinIn(pinIn),
    .pinOut(pinOut), .pinOe(pinOe), .irq(irq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic busWr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWData = d; busWrite = 1'b1;
    @(negedge clk);
    busWrite = 1'b0;
  endtask

  task automatic busRd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRData;
  endtask

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // scoreboard monitor: pin 0 level, one expected item per cycle
  always @(negedge clk) begin
    #1;
    if (expQ.size() > 0) begin
      automatic logic  e = expQ.pop_front();
      automatic string t = expTag.pop_front();
      check(t, {31'd0, pinOut[0]}, {31'd0, e});
    end
  end

  task automatic pushWave(int per, int wid, bit inv, int cycles, string tag);
    for (int k = 0; k < cycles; k++) begin
      expQ.push_back(((k % per) < wid) ^ inv);
      expTag.push_back(tag);
    end
  endtask

  task automatic drivePulse(int ch, int h, int l);
    pinIn[ch] = 1'b0; waitCyc(3);
    pinIn[ch] = 1'b1; waitCyc(h);
    pinIn[ch] = 1'b0; waitCyc(l);
    pinIn[ch] = 1'b1; waitCyc(6);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] rd2;
    waitCyc(5);
    rstN = 1'b1;
    waitCyc(2);

    // R1 reset state
    busRd(4'd0, rd);  check("R1 control word", rd, 32'h0);
    busRd(4'd4, rd);  check("R1 cfg0", rd, 32'h0);
    busRd(4'd14, rd); check("R1 period2", rd, 32'h0);
    check("R1 pinOe", {29'd0, pinOe}, 32'h0);
    check("R1 pinOut", {29'd0, pinOut}, 32'h0);
    check("R1 irq", {29'd0, irq}, 32'h0);

    // R4 R5 R11 waveform, period 5 width 2
    busWr(4'd6, 32'd5);
    busWr(4'd7, 32'd2);
    busWr(4'd4, 32'h19);
    busWr(4'd0, 32'h1);
    pushWave(5, 2, 1'b0, 10, "R4 wave pin");
    wait (expQ.size() == 0);
    waitCyc(1);
    check("R4 pinOe", {31'd0, pinOe[0]}, 32'd1);
    busRd(4'd0, rd);
    check("R5 wrap flag", {31'd0, rd[8]}, 32'd1);
    check("R11 irq0", {31'd0, irq[0]}, 32'd1);
    busRd(4'd13, rd); check("R2 disabled count2 held", rd, 32'd0);

    // R3 config write ignored while enabled
    busWr(4'd4, 32'h02);
    busRd(4'd4, rd); check("R3 cfg locked", rd, 32'h19);

    // R2 disable holds count, R10 clear
    busWr(4'd0, 32'h0);
    busRd(4'd5, rd); waitCyc(4); busRd(4'd5, rd2);
    check("R2 count held", rd2, rd);
    busWr(4'd0, 32'h100);
    busRd(4'd0, rd); check("R10 flag cleared", rd, 32'h0);
    check("R11 irq0 low", {31'd0, irq[0]}, 32'd0);

    // R4 inverted polarity, width 3
    busWr(4'd5, 32'd0);
    busRd(4'd5, rd); check("R2 count write when off", rd, 32'd0);
    busWr(4'd7, 32'd3);
    busWr(4'd4, 32'h1D);
    busRd(4'd4, rd); check("R3 cfg accepted when off", rd, 32'h1D);
    busWr(4'd0, 32'h1);
    pushWave(5, 3, 1'b1, 10, "R4 inverted pin");
    wait (expQ.size() == 0);
    busWr(4'd0, 32'h100);

    // R6 R7 capture on channel 1
    busWr(4'd8, 32'h0A);
    busWr(4'd0, 32'h2);
    drivePulse(1, 7, 5);
    busRd(4'd11, rd); check("R6 width 7", rd, 32'd7);
    busRd(4'd10, rd); check("R6 period 12", rd, 32'd12);
    busRd(4'd0, rd);  check("R7 capture flag", {31'd0, rd[9]}, 32'd1);
    check("R11 irq1", {31'd0, irq[1]}, 32'd1);
    check("R4 capture no drive", {31'd0, pinOe[1]}, 32'd0);
    busWr(4'd0, 32'h200);
    pinIn[1] = 1'b0;
    waitCyc(3);
    busWr(4'd0, 32'h2);
    drivePulse(1, 3, 9);
    busRd(4'd11, rd); check("R6 width 3", rd, 32'd3);
    busRd(4'd10, rd); check("R6 period 12 second", rd, 32'd12);
    busWr(4'd0, 32'h200);

    // R8 R9 watchdog on channel 2, period 10
    busWr(4'd13, 32'd0);
    busWr(4'd14, 32'd10);
    busWr(4'd12, 32'h0B);
    busWr(4'd0, 32'h4);
    for (int n = 0; n < 5; n++) begin
      pinIn[2] = 1'b1; waitCyc(3);
      pinIn[2] = 1'b0; waitCyc(3);
    end
    busRd(4'd0, rd);
    check("R8 no overflow", {31'd0, rd[18]}, 32'd0);
    check("R8 no event", {31'd0, rd[10]}, 32'd0);
    waitCyc(14);
    busRd(4'd0, rd);
    check("R9 overflow", {31'd0, rd[18]}, 32'd1);
    check("R9 event", {31'd0, rd[10]}, 32'd1);
    check("R11 irq2", {31'd0, irq[2]}, 32'd1);
    busWr(4'd0, 32'h0);
    busWr(4'd0, 32'h40400);
    busRd(4'd0, rd); check("R10 both flags cleared", rd, 32'h0);
    check("R1 irq idle again", {29'd0, irq}, 32'h0);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule